// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block sits on the host side of a parallel flash interface and decides when an internal program or erase operation in the flash has finished. Once the command sequence has been issued elsewhere, a sequencer pulses `start_i`. With the pulse it supplies the operation type, the byte that was written, the polling method, a maximum number of reads and the idle gap to leave between reads. The controller then issues status reads. For each read it raises a one-cycle request and waits for the returned byte. It judges each returned byte and ends with a single-cycle `done_o` or `timeout_o` pulse.

Two completion methods can be selected. The inverted-data method watches bit 7 of the returned byte. During a program, bit 7 reads as the complement of the written bit 7 until the operation finishes, and then reads true. During an erase, bit 7 reads 0 while busy and 1 once finished. The toggle method watches bit 6, which alternates between reads while the flash is busy. Here the controller groups reads into non-overlapping pairs. The first read of each pair only records bit 6, and the second read compares against it. Equal values mean the operation is complete.

Top module: `fpoll_ctrl`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `busy_o`, `rd_req_o`, `done_o` and `timeout_o` are all 0.
- R2: A `start_i` sampled high while idle latches `method_i`, `erase_i`, `expect_i`, `limit_i` and `gap_i`. In the following cycle `busy_o` and `rd_req_o` are both 1.
- R3: `rd_req_o` is a one-cycle pulse. The next request follows the previous one by exactly 1 + L + G cycles, where L is the number of cycles from the request to the `rd_valid_i` cycle and G is the latched gap value.
- R4: With `method_i`=0 and `erase_i`=0 (program), a returned byte whose bit 7 equals bit 7 of the latched expected byte completes the poll.
- R5: With `method_i`=0 and `erase_i`=1 (erase), a returned byte with bit 7 = 1 completes the poll, and bit 7 = 0 means busy.
- R6: With `method_i`=1, reads form non-overlapping pairs counted from the start. The poll completes on the second read of a pair when its bit 6 equals bit 6 of the first read of that pair.
- R7: If no read completes the poll within max(`limit_i`,1) reads, `timeout_o` pulses after the last permitted read, no further request is made and the controller returns to idle.
- R8: `done_o` and `timeout_o` are single-cycle pulses, never high together, and appear in the cycle after the `rd_valid_i` cycle that ended the poll.
- R9: A `start_i` while `busy_o` is 1 is ignored: the latched configuration, the read count and the outcome are those of the poll already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a poll (only accepted while idle) |
| method_i | input | 1 | 0 = inverted-data bit 7 method, 1 = toggle bit 6 method |
| erase_i | input | 1 | 0 = program operation, 1 = erase operation |
| expect_i | input | DW | Byte that was programmed (bit 7 used for program polling) |
| limit_i | input | CNT_W | Maximum number of reads, 0 treated as 1 |
| gap_i | input | GAP_W | Idle cycles inserted between a returned read and the next request |
| rd_req_o | output | 1 | One-cycle read request toward the flash |
| rd_valid_i | input | 1 | Returned byte valid, one cycle per request |
| rd_data_i | input | DW | Byte returned by the flash |
| busy_o | output | 1 | A poll is in progress |
| done_o | output | 1 | One-cycle pulse: operation finished |
| timeout_o | output | 1 | One-cycle pulse: read budget used up without completion |

## Verification
The assertions assume that the flash side answers every request with exactly one `rd_valid_i` cycle and never raises `rd_valid_i` without an outstanding request. Under that assumption the completion and timeout pulses can always be traced back to a returned byte. The bench models the flash with a fixed response latency per run, so each valid follows its request and no valid is unsolicited. The bench also varies the number of busy reads, the gap, the latency, the read budget, the method and the operation type across a full sweep. A second start is injected only mid-poll, where the design must ignore it.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_GAP  = 2'd3
    } fp_state_e;

endpackage

// File: rtl/fpoll_judge.sv
module fpoll_judge (
    input  logic method_i,
    input  logic erase_i,
    input  logic exp_bit_i,
    input  logic primed_i,
    input  logic prev_bit_i,
    input  logic poll_bit_i,
    input  logic tgl_bit_i,
    output logic complete_o
);
    logic data_done;
    logic tgl_done;

    always_comb begin
        // inverted-data method: erase finishes on a 1, program on the true bit
        data_done  = erase_i ? poll_bit_i : (poll_bit_i == exp_bit_i);
        // toggle method: only the second read of a pair may decide
        tgl_done   = primed_i && (tgl_bit_i == prev_bit_i);
        complete_o = method_i ? tgl_done : data_done;
    end
endmodule

// File: rtl/fpoll_pacer.sv
module fpoll_pacer #(
    parameter int GAP_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [GAP_W-1:0] len_i,
    input  logic             run_i,
    output logic             last_o
);
    logic [GAP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = len_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q <= GAP_W'(1));

    // R3
    gap_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (cnt_q != '0));
endmodule

// File: rtl/fpoll_ctrl.sv
module fpoll_ctrl
    import fpoll_pkg::*;
#(
    parameter int DW       = 8,
    parameter int CNT_W    = 16,
    parameter int GAP_W    = 4,
    parameter int POLL_BIT = 7,
    parameter int TGL_BIT  = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             method_i,
    input  logic             erase_i,
    input  logic [DW-1:0]    expect_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic [GAP_W-1:0] gap_i,
    output logic             rd_req_o,
    input  logic             rd_valid_i,
    input  logic [DW-1:0]    rd_data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             timeout_o
);
    localparam int CNT_X = CNT_W + 1;

    typedef struct packed {
        fp_state_e        st;
        logic             method;
        logic             erase;
        logic             exp_bit;
        logic             primed;
        logic             prev;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic [GAP_W-1:0] gap;
        logic             done;
        logic             tmo;
    } ctrl_t;

    ctrl_t      s_d, s_q;
    logic       complete;
    logic       pace_load;
    logic       pace_last;
    logic [CNT_X-1:0] cnt_inc;
    logic       bus_unused;

    assign bus_unused = ^{rd_data_i, expect_i};

    fpoll_judge judge_i (
        .method_i   (s_q.method),
        .erase_i    (s_q.erase),
        .exp_bit_i  (s_q.exp_bit),
        .primed_i   (s_q.primed),
        .prev_bit_i (s_q.prev),
        .poll_bit_i (rd_data_i[POLL_BIT]),
        .tgl_bit_i  (rd_data_i[TGL_BIT]),
        .complete_o (complete)
    );

    fpoll_pacer #(.GAP_W(GAP_W)) pacer_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (pace_load),
        .len_i  (s_q.gap),
        .run_i  (s_q.st == ST_GAP),
        .last_o (pace_last)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.tmo   = 1'b0;
        pace_load = 1'b0;
        cnt_inc   = {1'b0, s_q.cnt} + CNT_X'(1);
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st      = ST_REQ;
                    s_d.method  = method_i;
                    s_d.erase   = erase_i;
                    s_d.exp_bit = expect_i[POLL_BIT];
                    s_d.primed  = 1'b0;
                    s_d.prev    = 1'b0;
                    s_d.cnt     = '0;
                    s_d.lim     = (limit_i == '0) ? CNT_W'(1) : limit_i;
                    s_d.gap     = gap_i;
                end
            end
            ST_REQ: s_d.st = ST_WAIT;
            ST_WAIT: begin
                if (rd_valid_i) begin
                    s_d.cnt = cnt_inc[CNT_W-1:0];
                    if (complete) begin
                        s_d.done = 1'b1;
                        s_d.st   = ST_IDLE;
                    end else if (cnt_inc >= {1'b0, s_q.lim}) begin
                        s_d.tmo = 1'b1;
                        s_d.st  = ST_IDLE;
                    end else begin
                        if (s_q.method) begin
                            s_d.primed = ~s_q.primed;
                            s_d.prev   = rd_data_i[TGL_BIT];
                        end
                        pace_load = 1'b1;
                        s_d.st    = (s_q.gap == '0) ? ST_REQ : ST_GAP;
                    end
                end
            end
            ST_GAP: if (pace_last) s_d.st = ST_REQ;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{st: ST_IDLE, default: '0};
        else         s_q <= s_d;
    end

    assign rd_req_o  = (s_q.st == ST_REQ);
    assign busy_o    = (s_q.st != ST_IDLE);
    assign done_o    = s_q.done;
    assign timeout_o = s_q.tmo;

    // R3
    req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_req_o |=> !rd_req_o);
    // R8
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    // R8
    end_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && timeout_o));
    // R8
    end_after_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o || timeout_o) |-> ($past(rd_valid_i) && !busy_o));
    // R7
    budget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (s_q.cnt < s_q.lim));
    // R9
    cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> (!busy_o || ($stable(s_q.method) && $stable(s_q.erase) && $stable(s_q.lim))));
endmodule

// File: tb/fpoll_ctrl_tb.sv
module fpoll_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        method_i = 1'b0;
    logic        erase_i = 1'b0;
    logic [7:0]  expect_i = '0;
    logic [15:0] limit_i = '0;
    logic [3:0]  gap_i = '0;
    logic        rd_req_o;
    logic        rd_valid_i = 1'b0;
    logic [7:0]  rd_data_i = '0;
    logic        busy_o, done_o, timeout_o;

    int checks = 0;
    int errors = 0;

    int         c_method, c_op, c_busy;
    logic [7:0] c_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpoll_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .method_i(method_i),
        .erase_i(erase_i), .expect_i(expect_i), .limit_i(limit_i), .gap_i(gap_i),
        .rd_req_o(rd_req_o), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
        .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // flash status byte for read number i of the current poll
    function automatic logic [7:0] gen(input int i);
        logic [7:0] d;
        d = 8'h5A ^ 8'(i * 29);
        if (c_method == 0) begin
            if (i < c_busy) d[7] = (c_op != 0) ? 1'b0 : ~c_exp[7];
            else            d[7] = (c_op != 0) ? 1'b1 : c_exp[7];
        end else begin
            d[6] = (i < c_busy) ? i[0] : ~c_busy[0];
        end
        return d;
    endfunction

    task automatic run(input int m, input int op, input int nb, input int g,
                       input int lat, input int lim, input bit inj);
        int need, limeff, exp_reads, nreq, ndone, ntmo, ridx, pend;
        int last_req, last_valid, fin_cyc, gapbad, cyc, post;
        bit exp_done, fin;
        string tag;
        c_method = m; c_op = op; c_busy = nb;
        c_exp = nb[0] ? 8'hC3 : 8'h3C;
        limeff = (lim == 0) ? 1 : lim;
        need = (m == 0) ? nb + 1 : (nb[0] ? nb + 1 : nb + 2);
        exp_done = (need <= limeff);
        exp_reads = exp_done ? need : limeff;
        if (inj) tag = "R9";
        else if (!exp_done) tag = "R7";
        else if (m != 0) tag = "R6";
        else if (op != 0) tag = "R5";
        else tag = "R4";

        @(negedge clk);
        start_i = 1'b1; method_i = m[0]; erase_i = op[0]; expect_i = c_exp;
        limit_i = lim[15:0]; gap_i = g[3:0];
        @(negedge clk);
        start_i = 1'b0;
        // R2: request and busy in the cycle after start
        chk(rd_req_o && busy_o, "R2", int'(rd_req_o) + 2 * int'(busy_o), 3);
        nreq = 0; ndone = 0; ntmo = 0; ridx = 0; pend = 0; gapbad = 0;
        last_req = -1; last_valid = -100; fin_cyc = -1; cyc = 0; post = 0; fin = 0;
        while (post < 4 && cyc < 2000) begin
            if (inj && cyc == 3) begin
                start_i = 1'b1; method_i = ~m[0]; erase_i = ~op[0];
                limit_i = 16'd1; gap_i = 4'd0;
            end else begin
                start_i = 1'b0;
            end
            rd_valid_i = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    rd_valid_i = 1'b1;
                    rd_data_i = gen(ridx);
                    ridx++;
                    last_valid = cyc;
                end
            end
            if (rd_req_o) begin
                if (last_req >= 0 && (cyc - last_req) != 1 + lat + g) gapbad++;
                last_req = cyc;
                nreq++;
                pend = lat;
            end
            if (done_o) begin ndone++; if (fin_cyc < 0) fin_cyc = cyc; end
            if (timeout_o) begin ntmo++; if (fin_cyc < 0) fin_cyc = cyc; end
            if (fin) post++;
            if (done_o || timeout_o) fin = 1'b1;
            cyc++;
            @(negedge clk);
        end
        start_i = 1'b0;
        rd_valid_i = 1'b0;
        chk(fin, "R7 watchdog", int'(fin), 1);
        chk(ndone == int'(exp_done) && ntmo == int'(!exp_done), tag,
            ndone * 10 + ntmo, int'(exp_done) * 10 + int'(!exp_done));
        chk(nreq == exp_reads, tag, nreq, exp_reads);
        chk(gapbad == 0, "R3", gapbad, 0);
        chk(fin_cyc - last_valid == 1, "R8", fin_cyc - last_valid, 1);
        chk(!busy_o, "R7", int'(busy_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        chk(!busy_o && !rd_req_o && !done_o && !timeout_o, "R1",
            int'(busy_o) + int'(rd_req_o) + int'(done_o) + int'(timeout_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !rd_req_o && !done_o && !timeout_o, "R1",
            int'(busy_o) + int'(rd_req_o) + int'(done_o) + int'(timeout_o), 0);

        for (int m = 0; m < 2; m++)
            for (int op = 0; op < 2; op++)
                for (int nb = 0; nb < 6; nb++)
                    for (int g = 0; g < 3; g++)
                        for (int lat = 1; lat < 3; lat++) begin
                            run(m, op, nb, g, lat, 3, 1'b0);
                            run(m, op, nb, g, lat, 8, 1'b0);
                        end
        // R7: zero budget behaves as a single read
        run(0, 0, 4, 1, 1, 0, 1'b0);
        run(1, 1, 0, 0, 2, 0, 1'b0);
        // R9: second start during an active poll
        run(0, 0, 5, 1, 1, 8, 1'b1);
        run(1, 0, 4, 2, 2, 8, 1'b1);
        run(0, 1, 3, 0, 1, 8, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule